// File: doc/BRIEF.md
# Register Rename Status File

This block is the architectural floating-point register file of a dynamically scheduled core. Each register holds a data value, a pending flag and a producer tag. A clear pending flag means the register value is current. A set pending flag means the value will arrive later from the reservation station named by the tag. Tag value 0 is reserved and means "value present". It is never used as a producer name.

Each cycle the file serves two source lookups and one destination rename. A lookup returns either the register value with tag 0, or the pending producer's tag with data 0. A rename marks the destination pending under the issuing station's tag. That tag replaces any older producer tag, so a late result from an older writer cannot overwrite the register.

The file also watches the result broadcast bus. A broadcast is written into a register only when the register is pending and its current tag equals the broadcast tag. Within one cycle, the broadcast is seen first, then the source lookups, then the rename. As a result, a lookup forwards a matching broadcast value in the same cycle. A source that is also the destination reads the old value before the register becomes pending.

Top module: `rename_status_file`

## Requirements
- R1: After synchronous reset every register is not pending, with tag 0 and value 0, so every lookup returns tag 0 and data 0.
- R2: A lookup of a register that is not pending returns the stored value with tag 0.
- R3: A lookup of a pending register returns its producer tag (never 0) with data 0, unless R9 applies.
- R4: When issue_valid is 1, the register selected by dst_idx becomes pending with tag issue_tag from the next cycle. issue_tag must be nonzero.
- R5: A newer rename of a pending register replaces its tag. A later broadcast carrying the old tag leaves that register pending under the new tag.
- R6: A broadcast (bc_valid 1) whose tag equals a pending register's tag writes bc_data into that register, clears its pending flag and sets its tag to 0 from the next cycle.
- R7: A broadcast whose tag matches no pending register's tag leaves every register unchanged. A broadcast of tag 0 never matches anything.
- R8: When a source index equals dst_idx during an issue and that register is not pending, the lookup returns the old value with tag 0, and the register is pending from the next cycle.
- R9: A broadcast in the same cycle as a lookup is applied first. A source waiting on the broadcast tag returns bc_data with tag 0 in that same cycle.
- R10: When a broadcast completes a register in the same cycle that a rename targets it, the rename wins. The register is pending with the new tag in the next cycle.
- R11: With issue_valid 0, dst_idx and issue_tag have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| src_a_idx | input | 2 | First source register index |
| src_b_idx | input | 2 | Second source register index |
| dst_idx | input | 2 | Destination register index |
| issue_tag | input | 4 | Tag of the reservation station receiving the instruction |
| bc_valid | input | 1 | Result broadcast present this cycle |
| bc_tag | input | 4 | Tag of the broadcasting producer |
| bc_data | input | 32 | Broadcast result value |
| src_a_tag | output | 4 | First source: producer tag, 0 when data is valid |
| src_a_data | output | 32 | First source value when src_a_tag is 0 |
| src_b_tag | output | 4 | Second source: producer tag, 0 when data is valid |
| src_b_data | output | 32 | Second source value when src_b_tag is 0 |

## Verification
The assertions check the following on every cycle:
- a rename leaves the target pending under the issued tag;
- a matching broadcast completes a register with the broadcast value;
- a register with no rename and no match keeps its state;
- an idle register carries tag 0;
- each lookup either forwards the broadcast or reports the register's state correctly.

Some behaviours involve several cycles and only the directed scenarios show them:
- tag replacement across successive writers, and a stale broadcast that is ignored;
- read-before-rename when a source is also the destination;
- the rename taking priority over a completing broadcast.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    parameter int TAG_W  = 4;
    parameter int DATA_W = 32;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam tag_t READY_TAG = '0;

    typedef struct packed {
        logic  busy;
        tag_t  tag;
        data_t value;
    } reg_state_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bcast_t;

    typedef struct packed {
        tag_t  tag;
        data_t data;
    } operand_t;

    function automatic logic bcast_hits(bcast_t b, reg_state_t s);
        return b.valid && s.busy && (b.tag == s.tag) && (b.tag != READY_TAG);
    endfunction

endpackage

// File: rtl/rsf_entry.sv
module rsf_entry
    import rsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bcast_t     bc,
    input  logic       rename_en,
    input  tag_t       rename_tag,
    output reg_state_t state
);

    reg_state_t state_q;
    reg_state_t state_d;
    logic       hit;

    assign hit   = bcast_hits(bc, state_q);
    assign state = state_q;

    always_comb begin
        state_d = state_q;
        if (hit) begin
            state_d.busy  = 1'b0;
            state_d.tag   = READY_TAG;
            state_d.value = bc.data;
        end
        if (rename_en) begin
            state_d.busy = 1'b1;
            state_d.tag  = rename_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    p_rename_pending_r4: assert property (@(posedge clk) disable iff (rst)
        rename_en |=> (state_q.busy && state_q.tag == $past(rename_tag)));

    p_match_completes_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && !rename_en) |=> (!state_q.busy && state_q.value == $past(bc.data)));

    p_quiet_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!hit && !rename_en) |=> $stable(state_q));

    p_idle_tag_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !state_q.busy |-> state_q.tag == READY_TAG);

endmodule

// File: rtl/rsf_read_port.sv
module rsf_read_port
    import rsf_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  reg_state_t [NUM_REGS-1:0] states,
    input  logic [IDX_W-1:0]          idx,
    input  bcast_t                    bc,
    output operand_t                  opnd
);

    reg_state_t sel;
    logic       fwd;

    assign sel = states[idx];
    assign fwd = bcast_hits(bc, sel);

    always_comb begin
        if (!sel.busy) begin
            opnd.tag  = READY_TAG;
            opnd.data = sel.value;
        end else if (fwd) begin
            opnd.tag  = READY_TAG;
            opnd.data = bc.data;
        end else begin
            opnd.tag  = sel.tag;
            opnd.data = '0;
        end
    end

    p_pending_reports_tag_r3: assert property (@(posedge clk) disable iff (rst)
        (states[idx].busy && !(bc.valid && bc.tag == states[idx].tag))
            |-> (opnd.tag != READY_TAG && opnd.data == '0));

    p_forward_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (states[idx].busy && bc.valid && bc.tag == states[idx].tag)
            |-> (opnd.tag == READY_TAG && opnd.data == bc.data));

endmodule

// File: rtl/rename_status_file.sv
module rename_status_file
    import rsf_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int NUM_SRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_a_data,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic [DATA_W-1:0] src_b_data
);

    bcast_t                    bc;
    reg_state_t [NUM_REGS-1:0] states;
    logic [IDX_W-1:0]          src_idx [NUM_SRC];
    operand_t                  src_opnd [NUM_SRC];

    assign bc.valid = bc_valid;
    assign bc.tag   = bc_tag;
    assign bc.data  = bc_data;

    assign src_idx[0] = src_a_idx;
    assign src_idx[1] = src_b_idx;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            rsf_entry u_entry (
                .clk        (clk),
                .rst        (rst),
                .bc         (bc),
                .rename_en  (issue_valid && (dst_idx == IDX_W'(gi))),
                .rename_tag (issue_tag),
                .state      (states[gi])
            );
        end
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            rsf_read_port #(.NUM_REGS(NUM_REGS)) u_port (
                .clk    (clk),
                .rst    (rst),
                .states (states),
                .idx    (src_idx[gi]),
                .bc     (bc),
                .opnd   (src_opnd[gi])
            );
        end
    endgenerate

    assign src_a_tag  = src_opnd[0].tag;
    assign src_a_data = src_opnd[0].data;
    assign src_b_tag  = src_opnd[1].tag;
    assign src_b_data = src_opnd[1].data;

    p_issue_tag_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> issue_tag != READY_TAG);

    p_dest_pending_r10: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> (src_a_idx != $past(dst_idx)) || (src_a_tag == $past(issue_tag))
                        || (bc_valid && bc_tag == $past(issue_tag)));

endmodule

// File: tb/rename_status_file_bench.sv
module rename_status_file_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [1:0]  src_a_idx, src_b_idx, dst_idx;
    logic [3:0]  issue_tag;
    logic        bc_valid;
    logic [3:0]  bc_tag;
    logic [31:0] bc_data;
    logic [3:0]  src_a_tag, src_b_tag;
    logic [31:0] src_a_data, src_b_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rename_status_file u_rename_status_file (
        .clk(clk), .rst(rst), .issue_valid(issue_valid),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .issue_tag(issue_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .bc_data(bc_data), .src_a_tag(src_a_tag), .src_a_data(src_a_data),
        .src_b_tag(src_b_tag), .src_b_data(src_b_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        issue_valid = 1'b0; dst_idx = 2'd0; issue_tag = 4'd0;
        bc_valid = 1'b0; bc_tag = 4'd0; bc_data = 32'd0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic expect_reg(input string req, input logic [1:0] r,
                              input logic [3:0] tag, input logic [31:0] data);
        src_a_idx = r; src_b_idx = r;
        #1;
        check({req, " port A tag"}, 32'(src_a_tag), 32'(tag));
        check({req, " port A data"}, src_a_data, data);
        check({req, " port B tag"}, 32'(src_b_tag), 32'(tag));
        check({req, " port B data"}, src_b_data, data);
    endtask

    task automatic issue(input logic [1:0] d, input logic [3:0] t);
        issue_valid = 1'b1; dst_idx = d; issue_tag = t;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [31:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_data = v;
    endtask

    task automatic t_reset();
        for (int r = 0; r < 4; r++) expect_reg("R1", 2'(r), 4'd0, 32'd0);
    endtask

    task automatic t_rename_and_complete();
        issue(2'd0, 4'd4); step();
        expect_reg("R4 R3", 2'd0, 4'd4, 32'd0);
        bcast(4'd4, 32'h0000_000A); step();
        expect_reg("R6 R2", 2'd0, 4'd0, 32'h0000_000A);
    endtask

    task automatic t_newer_writer();
        issue(2'd0, 4'd10); step();
        issue(2'd0, 4'd11); step();
        expect_reg("R5 replace", 2'd0, 4'd11, 32'd0);
        bcast(4'd10, 32'h55); step();
        expect_reg("R5 stale ignored", 2'd0, 4'd11, 32'd0);
        bcast(4'd11, 32'h77); step();
        expect_reg("R5 newest lands", 2'd0, 4'd0, 32'h77);
    endtask

    task automatic t_nonmatch();
        issue(2'd1, 4'd5); step();
        bcast(4'd5, 32'h11); step();
        bcast(4'd9, 32'hDEAD); step();
        expect_reg("R7 reg0", 2'd0, 4'd0, 32'h77);
        expect_reg("R7 reg1", 2'd1, 4'd0, 32'h11);
        bcast(4'd0, 32'hBEEF); step();
        expect_reg("R7 tag0 reg0", 2'd0, 4'd0, 32'h77);
        expect_reg("R7 tag0 reg3", 2'd3, 4'd0, 32'd0);
    endtask

    task automatic t_self_read();
        src_a_idx = 2'd0; src_b_idx = 2'd1;
        issue(2'd0, 4'd12);
        #1;
        check("R8 old value", src_a_data, 32'h77);
        check("R8 old tag", 32'(src_a_tag), 32'd0);
        step();
        expect_reg("R8 now pending", 2'd0, 4'd12, 32'd0);
    endtask

    task automatic t_forward();
        src_a_idx = 2'd0; src_b_idx = 2'd1;
        bcast(4'd12, 32'h99);
        issue(2'd2, 4'd8);
        #1;
        check("R9 forwarded tag", 32'(src_a_tag), 32'd0);
        check("R9 forwarded data", src_a_data, 32'h99);
        check("R9 other port", src_b_data, 32'h11);
        step();
        expect_reg("R9 stored", 2'd0, 4'd0, 32'h99);
        expect_reg("R4 reg2", 2'd2, 4'd8, 32'd0);
    endtask

    task automatic t_collide();
        bcast(4'd8, 32'h33);
        issue(2'd2, 4'd9);
        step();
        expect_reg("R10 rename wins", 2'd2, 4'd9, 32'd0);
        bcast(4'd9, 32'h44); step();
        expect_reg("R10 later result", 2'd2, 4'd0, 32'h44);
    endtask

    task automatic t_no_issue();
        issue_valid = 1'b0; dst_idx = 2'd3; issue_tag = 4'd6;
        step();
        expect_reg("R11 reg3", 2'd3, 4'd0, 32'd0);
        expect_reg("R11 reg2", 2'd2, 4'd0, 32'h44);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        idle();
        src_a_idx = 2'd0; src_b_idx = 2'd0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rename_and_complete();
        t_newer_writer();
        t_nonmatch();
        t_self_read();
        t_forward();
        t_collide();
        t_no_issue();
        finish_run();
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule